// File: doc/BRIEF.md
# Radio Transceiver Power-Mode Sequencer

This block is the finite-state controller that takes a radio transceiver through its power and operating modes: off, wakeup, init, idle, transmit, receive and sleep. It watches a power-good input, host command strobes, a delayed-start request with a target time, a sleep-timer expiry tick and a PLL lock indication. From these it drives the enables for the crystal oscillator, the bandgap reference, the digital regulator, the PLL and the two analog front-end halves. It also drives a reset release, a core clock source select, a one-cycle configuration-restore strobe and a registered 3-bit state code.

The wakeup wait and the PLL switch-over window are counted in core-clock cycles, and both lengths are parameters. A free-running time counter is visible at the ports. A timed transmit or receive holds the controller in idle until that counter equals the target the host programmed. Two status outputs tell the host how fast it may clock the serial port: a speed-class flag, and a guard flag that marks the cycles around the clock-source switch.

Top module: `radio_pwr_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycles after it, `state_code` is 0 (off) and every enable, `rst_out_n`, `clk_src`, `spi_fast`, `spi_guard` and `restore_pulse` is low.
- R2: When `pwr_good` is seen high in off, the state becomes wakeup (code 1) with `osc_en` and `bg_en` high and `dreg_en`, `rst_out_n` low. It stays there for exactly WAKE_CYC cycles, then enters init (code 2) with `dreg_en` and `rst_out_n` high.
- R3: In init, `pll_en` is high, `clk_src` is 0 (divided crystal clock) and `spi_fast` is 0 (low-speed serial class).
- R4: `restore_pulse` is high for one cycle on entry to init after a sleep wake or after a host `cmd_reset` (accepted in init, idle, transmit or receive). Entry to init after a cold power-up, or over the idle-to-init return path, gives no pulse.
- R5: In init with `seq_en` high, the controller moves to idle (code 3) once `pll_lock` has been high for GUARD_CYC cycles. `spi_guard` is high for exactly GUARD_CYC cycles, and the last of them is the first idle cycle. Idle has `clk_src`=1 (PLL) and `spi_fast`=1. Without lock the controller stays in init.
- R6: With `seq_en` low, init never advances to idle. Idle returns to init only when `clk_sel_xtal` is high and `seq_en` is low; `clk_sel_xtal` alone has no effect.
- R7: In idle both `afe_tx_en` and `afe_rx_en` are low. With `dly_en` low, `cmd_tx` enters transmit (code 4, `afe_tx_en` high) and `cmd_rx` enters receive (code 5, `afe_rx_en` high) on the next cycle.
- R8: With `dly_en` high, a start command latches `dly_target` and the controller stays in idle, ignoring further start commands. It enters the requested state in the cycle after `time_now` equals the target, so the first active cycle shows `time_now` = target + 1.
- R9: `txrx_done` or `cmd_abort` returns transmit or receive to idle. `cmd_abort` in idle cancels a pending timed start.
- R10: `cmd_sleep` is accepted only in idle and has no effect in transmit. Sleep (code 6) holds every enable and `rst_out_n` low until `sleep_expire`, which moves the controller to wakeup.
- R11: `pwr_good` low in any state gives the off state on the next cycle, with all enables low.
- R12: `state_code` is a registered 3-bit code (0 off, 1 wakeup, 2 init, 3 idle, 4 transmit, 5 receive, 6 sleep). Code 7 never appears, and an illegal internal code recovers to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply valid |
| seq_en | input | 1 | Automatic sequencing enable |
| clk_sel_xtal | input | 1 | Host request for crystal clock source |
| cmd_tx | input | 1 | Start transmit strobe |
| cmd_rx | input | 1 | Start receive strobe |
| cmd_abort | input | 1 | Abort active or pending operation |
| cmd_sleep | input | 1 | Enter sleep strobe |
| cmd_reset | input | 1 | Host soft reset strobe |
| txrx_done | input | 1 | Transmit/receive completion pulse |
| dly_en | input | 1 | Start commands are timed |
| dly_target | input | TIME_W | Target time for a timed start |
| sleep_expire | input | 1 | Sleep counter expiry tick |
| pll_lock | input | 1 | PLL lock indication |
| osc_en | output | 1 | Crystal oscillator enable |
| bg_en | output | 1 | Bandgap enable |
| dreg_en | output | 1 | Digital regulator enable |
| pll_en | output | 1 | PLL enable |
| afe_tx_en | output | 1 | Transmit front-end enable |
| afe_rx_en | output | 1 | Receive front-end enable |
| rst_out_n | output | 1 | Digital reset release (high = released) |
| clk_src | output | 1 | Core clock source, 0 crystal/2, 1 PLL |
| spi_fast | output | 1 | Serial clock class, 0 low-speed, 1 full-speed |
| spi_guard | output | 1 | Clock switch-over in progress |
| restore_pulse | output | 1 | Configuration restore strobe |
| state_code | output | 3 | Current state code |
| time_now | output | TIME_W | Free-running time counter |

## Verification
The hardest situation to reach is a timed start that must be released on one exact count of the free-running counter, while start commands arriving in the meantime are ignored and an abort can still cancel it. The bench reads `time_now` at a falling edge and programs a target a fixed distance ahead. It then pulses a second, opposite start command during the wait and checks both the state that is entered and the counter value at entry. The switch-over window is reached through a counter-based PLL lock model whose lock can be held off. This allows the bench to test separately that init stays put without lock and that it stays put with sequencing disabled.

// File: rtl/radio_pwr_pkg.sv
package radio_pwr_pkg;

    typedef enum logic [2:0] {
        PM_OFF   = 3'd0,
        PM_WAKE  = 3'd1,
        PM_INIT  = 3'd2,
        PM_IDLE  = 3'd3,
        PM_TX    = 3'd4,
        PM_RX    = 3'd5,
        PM_SLEEP = 3'd6
    } pm_state_e;

    typedef struct packed {
        logic osc_en;
        logic bg_en;
        logic dreg_en;
        logic pll_en;
        logic afe_tx_en;
        logic afe_rx_en;
        logic rst_rel;
        logic clk_pll;
        logic spi_fast;
    } pm_ctl_t;

    typedef struct packed {
        pm_state_e st;
        logic      warm;
        logic      pend;
        logic      pend_rx;
        logic      restore;
        logic      guard;
    } pm_reg_t;

endpackage

// File: rtl/pwr_wait_cnt.sv
module pwr_wait_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (cnt_q == {CW{1'b1}})
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pwr_time_base.sv
module pwr_time_base #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [TW-1:0] tgt_in,
    output logic [TW-1:0] time_o,
    output logic          hit
);
    logic [TW-1:0] time_d, time_q;
    logic [TW-1:0] tgt_d, tgt_q;

    always_comb begin
        time_d = time_q + 1'b1;
        tgt_d  = arm ? tgt_in : tgt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
            tgt_q  <= '0;
        end else begin
            time_q <= time_d;
            tgt_q  <= tgt_d;
        end
    end

    assign time_o = time_q;
    assign hit    = (time_q == tgt_q);
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
    import radio_pwr_pkg::*;
(
    input  pm_state_e st,
    output pm_ctl_t   ctl
);
    always_comb begin
        ctl = '0;
        case (st)
            PM_WAKE: begin
                ctl.osc_en = 1'b1;
                ctl.bg_en  = 1'b1;
            end
            PM_INIT: begin
                ctl.osc_en  = 1'b1;
                ctl.bg_en   = 1'b1;
                ctl.dreg_en = 1'b1;
                ctl.pll_en  = 1'b1;
                ctl.rst_rel = 1'b1;
            end
            PM_IDLE, PM_TX, PM_RX: begin
                ctl.osc_en    = 1'b1;
                ctl.bg_en     = 1'b1;
                ctl.dreg_en   = 1'b1;
                ctl.pll_en    = 1'b1;
                ctl.rst_rel   = 1'b1;
                ctl.clk_pll   = 1'b1;
                ctl.spi_fast  = 1'b1;
                ctl.afe_tx_en = (st == PM_TX);
                ctl.afe_rx_en = (st == PM_RX);
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/radio_pwr_seq.sv
module radio_pwr_seq
    import radio_pwr_pkg::*;
#(
    parameter int WAKE_CYC  = 76800,
    parameter int GUARD_CYC = 96,
    parameter int TIME_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              seq_en,
    input  logic              clk_sel_xtal,
    input  logic              cmd_tx,
    input  logic              cmd_rx,
    input  logic              cmd_abort,
    input  logic              cmd_sleep,
    input  logic              cmd_reset,
    input  logic              txrx_done,
    input  logic              dly_en,
    input  logic [TIME_W-1:0] dly_target,
    input  logic              sleep_expire,
    input  logic              pll_lock,
    output logic              osc_en,
    output logic              bg_en,
    output logic              dreg_en,
    output logic              pll_en,
    output logic              afe_tx_en,
    output logic              afe_rx_en,
    output logic              rst_out_n,
    output logic              clk_src,
    output logic              spi_fast,
    output logic              spi_guard,
    output logic              restore_pulse,
    output logic [2:0]        state_code,
    output logic [TIME_W-1:0] time_now
);
    localparam int MAX_WAIT = (WAKE_CYC > GUARD_CYC) ? WAKE_CYC : GUARD_CYC;
    localparam int CW       = $clog2(MAX_WAIT + 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYC - 1);

    pm_reg_t r_d, r_q;
    pm_ctl_t ctl_d, ctl_q;

    logic [CW-1:0] wcnt;
    logic          wclr;
    logic          wcond;
    logic          arm_d;
    logic          hit;
    logic          lock_ok;
    logic          reset_ok;

    pwr_wait_cnt #(.CW(CW)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wclr),
        .cnt   (wcnt)
    );

    pwr_time_base #(.TW(TIME_W)) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_d),
        .tgt_in (dly_target),
        .time_o (time_now),
        .hit    (hit)
    );

    pwr_out_decode u_dec (
        .st  (r_d.st),
        .ctl (ctl_d)
    );

    assign lock_ok  = pll_lock && seq_en;
    assign reset_ok = (r_q.st == PM_INIT) || (r_q.st == PM_IDLE) ||
                      (r_q.st == PM_TX)   || (r_q.st == PM_RX);

    // next-state and flag computation
    always_comb begin
        r_d         = r_q;
        r_d.restore = 1'b0;
        arm_d       = 1'b0;
        if (!pwr_good) begin
            r_d.st   = PM_OFF;
            r_d.warm = 1'b0;
            r_d.pend = 1'b0;
        end else if (cmd_reset && reset_ok) begin
            r_d.st      = PM_INIT;
            r_d.pend    = 1'b0;
            r_d.restore = 1'b1;
        end else begin
            case (r_q.st)
                PM_OFF: begin
                    r_d.warm = 1'b0;
                    r_d.st   = PM_WAKE;
                end
                PM_WAKE: begin
                    if (wcnt == WAKE_LAST) begin
                        r_d.st      = PM_INIT;
                        r_d.restore = r_q.warm;
                        r_d.warm    = 1'b0;
                    end
                end
                PM_INIT: begin
                    if (lock_ok && (wcnt == GUARD_LAST))
                        r_d.st = PM_IDLE;
                end
                PM_IDLE: begin
                    if (cmd_abort) begin
                        r_d.pend = 1'b0;
                    end else if (r_q.pend) begin
                        if (hit) begin
                            r_d.st   = r_q.pend_rx ? PM_RX : PM_TX;
                            r_d.pend = 1'b0;
                        end
                    end else if (clk_sel_xtal && !seq_en) begin
                        r_d.st = PM_INIT;
                    end else if (cmd_sleep) begin
                        r_d.st = PM_SLEEP;
                    end else if (cmd_tx || cmd_rx) begin
                        if (dly_en) begin
                            r_d.pend    = 1'b1;
                            r_d.pend_rx = !cmd_tx;
                            arm_d       = 1'b1;
                        end else begin
                            r_d.st = cmd_tx ? PM_TX : PM_RX;
                        end
                    end
                end
                PM_TX, PM_RX: begin
                    if (txrx_done || cmd_abort)
                        r_d.st = PM_IDLE;
                end
                PM_SLEEP: begin
                    if (sleep_expire) begin
                        r_d.st   = PM_WAKE;
                        r_d.warm = 1'b1;
                    end
                end
                default: begin
                    r_d.st   = PM_OFF;
                    r_d.warm = 1'b0;
                    r_d.pend = 1'b0;
                end
            endcase
        end
        r_d.guard = ((r_d.st == PM_INIT) && lock_ok) ||
                    ((r_q.st == PM_INIT) && (r_d.st == PM_IDLE));
    end

    assign wcond = (r_q.st == PM_WAKE) || ((r_q.st == PM_INIT) && lock_ok);
    assign wclr  = !wcond || (r_d.st != r_q.st) || r_d.restore;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q   <= '{st: PM_OFF, default: 1'b0};
            ctl_q <= '0;
        end else begin
            r_q   <= r_d;
            ctl_q <= ctl_d;
        end
    end

    assign osc_en        = ctl_q.osc_en;
    assign bg_en         = ctl_q.bg_en;
    assign dreg_en       = ctl_q.dreg_en;
    assign pll_en        = ctl_q.pll_en;
    assign afe_tx_en     = ctl_q.afe_tx_en;
    assign afe_rx_en     = ctl_q.afe_rx_en;
    assign rst_out_n     = ctl_q.rst_rel;
    assign clk_src       = ctl_q.clk_pll;
    assign spi_fast      = ctl_q.spi_fast;
    assign spi_guard     = r_q.guard;
    assign restore_pulse = r_q.restore;
    assign state_code    = r_q.st;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic [2:0] state_code,
    input logic       osc_en,
    input logic       bg_en,
    input logic       dreg_en,
    input logic       pll_en,
    input logic       afe_tx_en,
    input logic       afe_rx_en,
    input logic       rst_out_n,
    input logic       clk_src,
    input logic       spi_fast,
    input logic       restore_pulse
);
    AST_OFF_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0) |-> !(osc_en || bg_en || dreg_en || pll_en || rst_out_n)); // R1
    AST_WAKE_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 3'd2) && ($past(state_code) == 3'd1)) |-> (dreg_en && rst_out_n)); // R2
    AST_INIT_SLOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2) |-> (pll_en && !clk_src && !spi_fast)); // R3
    AST_RESTORE_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        restore_pulse |-> (state_code == 3'd2)); // R4
    AST_IDLE_FAST_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3) |-> (clk_src && spi_fast)); // R5
    AST_AFE_TX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        afe_tx_en |-> (state_code == 3'd4)); // R7
    AST_AFE_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        afe_rx_en |-> (state_code == 3'd5)); // R7
    AST_SLEEP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 3'd6) && ($past(state_code) != 3'd6)) |-> ($past(state_code) == 3'd3)); // R10
    AST_SLEEP_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd6) |-> !(osc_en || bg_en || dreg_en || pll_en || rst_out_n)); // R10
    AST_PWR_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (state_code == 3'd0)); // R11
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 3'd7); // R12
endmodule

bind radio_pwr_seq pwr_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_good      (pwr_good),
    .state_code    (state_code),
    .osc_en        (osc_en),
    .bg_en         (bg_en),
    .dreg_en       (dreg_en),
    .pll_en        (pll_en),
    .afe_tx_en     (afe_tx_en),
    .afe_rx_en     (afe_rx_en),
    .rst_out_n     (rst_out_n),
    .clk_src       (clk_src),
    .spi_fast      (spi_fast),
    .restore_pulse (restore_pulse)
);

// File: tb/radio_pwr_seq_test.sv
`timescale 1ns/1ps
module radio_pwr_seq_test;
    localparam int WAKE_CYC  = 20;
    localparam int GUARD_CYC = 4;
    localparam int TIME_W    = 16;
    localparam int LOCK_DLY  = 6;

    localparam logic [2:0] S_OFF = 3'd0, S_WAKE = 3'd1, S_INIT = 3'd2, S_IDLE = 3'd3,
                           S_TX = 3'd4, S_RX = 3'd5, S_SLEEP = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, seq_en = 1'b1, clk_sel_xtal = 1'b0;
    logic cmd_tx = 1'b0, cmd_rx = 1'b0, cmd_abort = 1'b0, cmd_sleep = 1'b0, cmd_reset = 1'b0;
    logic txrx_done = 1'b0, dly_en = 1'b0, sleep_expire = 1'b0;
    logic [TIME_W-1:0] dly_target = '0;
    logic pll_lock;
    logic osc_en, bg_en, dreg_en, pll_en, afe_tx_en, afe_rx_en, rst_out_n;
    logic clk_src, spi_fast, spi_guard, restore_pulse;
    logic [2:0] state_code;
    logic [TIME_W-1:0] time_now;

    int checks = 0;
    int failures = 0;
    int rcnt = 0;
    int lk_cnt = 0;
    logic lock_allow = 1'b0;

    always #2.5 clk = ~clk;

    radio_pwr_seq #(.WAKE_CYC(WAKE_CYC), .GUARD_CYC(GUARD_CYC), .TIME_W(TIME_W)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .seq_en(seq_en),
        .clk_sel_xtal(clk_sel_xtal), .cmd_tx(cmd_tx), .cmd_rx(cmd_rx),
        .cmd_abort(cmd_abort), .cmd_sleep(cmd_sleep), .cmd_reset(cmd_reset),
        .txrx_done(txrx_done), .dly_en(dly_en), .dly_target(dly_target),
        .sleep_expire(sleep_expire), .pll_lock(pll_lock), .osc_en(osc_en),
        .bg_en(bg_en), .dreg_en(dreg_en), .pll_en(pll_en), .afe_tx_en(afe_tx_en),
        .afe_rx_en(afe_rx_en), .rst_out_n(rst_out_n), .clk_src(clk_src),
        .spi_fast(spi_fast), .spi_guard(spi_guard), .restore_pulse(restore_pulse),
        .state_code(state_code), .time_now(time_now)
    );

    // PLL lock model: lock after LOCK_DLY cycles of pll_en, unless held off
    always @(posedge clk) begin
        if (!pll_en || !lock_allow) lk_cnt <= 0;
        else if (lk_cnt < LOCK_DLY) lk_cnt <= lk_cnt + 1;
        if (restore_pulse) rcnt <= rcnt + 1;
    end
    assign pll_lock = (lk_cnt == LOCK_DLY);

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(input logic [2:0] code, input int maxc);
        for (int i = 0; i < maxc && state_code != code; i++) step(1);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        step(1);
        sig = 1'b0;
    endtask

    task automatic t_reset;
        step(3);
        chk(state_code == S_OFF, "R1", "state in reset", state_code, S_OFF);
        chk({osc_en, bg_en, dreg_en, pll_en, afe_tx_en, afe_rx_en, rst_out_n, clk_src,
             spi_fast, spi_guard, restore_pulse} == '0, "R1", "outputs in reset", 1, 0);
        rst_n = 1'b1;
        step(4);
        chk(state_code == S_OFF, "R11", "off without pwr_good", state_code, S_OFF);
        chk(osc_en == 1'b0, "R1", "osc after reset", osc_en, 0);
    endtask

    task automatic t_cold_up;
        int r0, wc;
        r0 = rcnt;
        pwr_good = 1'b1;
        step(1);
        chk(state_code == S_WAKE, "R2", "wakeup entry", state_code, S_WAKE);
        chk(osc_en && bg_en && !dreg_en && !rst_out_n, "R2", "wakeup enables", {osc_en, bg_en, dreg_en, rst_out_n}, 4'b1100);
        wc = 0;
        while (state_code == S_WAKE && wc < 1000) begin
            wc++;
            step(1);
        end
        chk(wc == WAKE_CYC, "R2", "wakeup length", wc, WAKE_CYC);
        chk(state_code == S_INIT && dreg_en && rst_out_n, "R2", "init with regulator", state_code, S_INIT);
        chk(pll_en && !clk_src && !spi_fast, "R3", "init clocking", {pll_en, clk_src, spi_fast}, 3'b100);
        step(15);
        chk(state_code == S_INIT, "R5", "no lock stays init", state_code, S_INIT);
        chk(rcnt - r0 == 0, "R4", "no restore on cold entry", rcnt - r0, 0);
    endtask

    task automatic t_lock_up;
        int g;
        seq_en = 1'b0;
        lock_allow = 1'b1;
        step(20);
        chk(state_code == S_INIT, "R6", "sequencing off stays init", state_code, S_INIT);
        chk(spi_guard == 1'b0, "R6", "no guard with sequencing off", spi_guard, 0);
        seq_en = 1'b1;
        g = 0;
        for (int i = 0; i < 50; i++) begin
            step(1);
            if (spi_guard) g++;
            if (state_code == S_IDLE) break;
        end
        chk(state_code == S_IDLE && spi_guard, "R5", "idle entry with guard", {state_code, spi_guard}, {S_IDLE, 1'b1});
        step(1);
        chk(g == GUARD_CYC && !spi_guard, "R5", "guard cycles", g, GUARD_CYC);
        chk(clk_src && spi_fast, "R5", "idle on PLL full-speed", {clk_src, spi_fast}, 2'b11);
        chk(!afe_tx_en && !afe_rx_en, "R7", "front end off in idle", {afe_tx_en, afe_rx_en}, 0);
    endtask

    task automatic t_immediate;
        pulse(cmd_tx);
        chk(state_code == S_TX && afe_tx_en && !afe_rx_en, "R7", "immediate transmit", state_code, S_TX);
        pulse(cmd_sleep);
        chk(state_code == S_TX, "R10", "sleep ignored in transmit", state_code, S_TX);
        pulse(txrx_done);
        chk(state_code == S_IDLE, "R9", "done returns idle", state_code, S_IDLE);
        pulse(cmd_rx);
        chk(state_code == S_RX && afe_rx_en && !afe_tx_en, "R7", "immediate receive", state_code, S_RX);
        pulse(cmd_abort);
        chk(state_code == S_IDLE, "R9", "abort returns idle", state_code, S_IDLE);
    endtask

    task automatic t_delayed;
        int tgt;
        dly_en = 1'b1;
        tgt = int'(time_now) + 12;
        dly_target = TIME_W'(tgt);
        pulse(cmd_tx);
        step(2);
        pulse(cmd_rx);
        step(2);
        chk(state_code == S_IDLE, "R8", "held in idle before target", state_code, S_IDLE);
        wait_state(S_TX, 40);
        chk(state_code == S_TX, "R8", "pending direction kept", state_code, S_TX);
        chk(int'(time_now) == ((tgt + 1) % (1 << TIME_W)), "R8", "entry time", time_now, tgt + 1);
        pulse(txrx_done);
        tgt = int'(time_now) + 10;
        dly_target = TIME_W'(tgt);
        pulse(cmd_rx);
        step(3);
        pulse(cmd_abort);
        step(20);
        chk(state_code == S_IDLE, "R9", "abort cancels pending", state_code, S_IDLE);
        dly_en = 1'b0;
    endtask

    task automatic t_sleep_cycle;
        int r0;
        r0 = rcnt;
        pulse(cmd_sleep);
        chk(state_code == S_SLEEP, "R10", "sleep entry", state_code, S_SLEEP);
        chk({osc_en, bg_en, dreg_en, pll_en, rst_out_n} == '0, "R10", "sleep enables", {osc_en, bg_en, dreg_en, pll_en, rst_out_n}, 0);
        step(10);
        chk(state_code == S_SLEEP, "R10", "sleep holds", state_code, S_SLEEP);
        pulse(sleep_expire);
        chk(state_code == S_WAKE, "R10", "expiry wakes", state_code, S_WAKE);
        wait_state(S_INIT, 60);
        step(2);
        chk(rcnt - r0 == 1, "R4", "restore after sleep", rcnt - r0, 1);
        wait_state(S_IDLE, 60);
        chk(state_code == S_IDLE, "R5", "relock to idle", state_code, S_IDLE);
    endtask

    task automatic t_return_init;
        int r0;
        r0 = rcnt;
        clk_sel_xtal = 1'b1;
        step(5);
        chk(state_code == S_IDLE, "R6", "crystal select alone ignored", state_code, S_IDLE);
        seq_en = 1'b0;
        step(1);
        chk(state_code == S_INIT, "R6", "return to init", state_code, S_INIT);
        chk(!clk_src && !spi_fast, "R3", "crystal clock in init", {clk_src, spi_fast}, 0);
        step(15);
        chk(state_code == S_INIT, "R6", "stays in init", state_code, S_INIT);
        chk(rcnt - r0 == 0, "R4", "no restore on return path", rcnt - r0, 0);
        seq_en = 1'b1;
        clk_sel_xtal = 1'b0;
        wait_state(S_IDLE, 40);
        chk(state_code == S_IDLE, "R5", "back to idle", state_code, S_IDLE);
    endtask

    task automatic t_host_reset;
        int r0;
        r0 = rcnt;
        pulse(cmd_reset);
        chk(state_code == S_INIT, "R4", "host reset to init", state_code, S_INIT);
        step(2);
        chk(rcnt - r0 == 1, "R4", "restore after host reset", rcnt - r0, 1);
        wait_state(S_IDLE, 40);
    endtask

    task automatic t_pwr_loss;
        int r0;
        pulse(cmd_tx);
        chk(state_code == S_TX, "R7", "transmit before power loss", state_code, S_TX);
        pwr_good = 1'b0;
        step(1);
        chk(state_code == S_OFF, "R11", "power loss to off", state_code, S_OFF);
        chk({osc_en, bg_en, dreg_en, pll_en, afe_tx_en, rst_out_n} == '0, "R11", "enables after power loss", 1, 0);
        r0 = rcnt;
        pwr_good = 1'b1;
        wait_state(S_INIT, 60);
        step(2);
        chk(rcnt - r0 == 0, "R4", "no restore after repower", rcnt - r0, 0);
        chk(state_code != 3'd7, "R12", "legal code", state_code, S_INIT);
    endtask

    initial begin
        t_reset();
        t_cold_up();
        t_lock_up();
        t_immediate();
        t_delayed();
        t_sleep_cycle();
        t_return_init();
        t_host_reset();
        t_pwr_loss();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule